// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is the digital model of a clock-distribution output stage. It runs on a fast tick clock, where one tick is one skew time unit. A free-running period counter wraps every N ticks. N is chosen by a range select. From that counter the block derives a nominal square wave with a 50% duty cycle, high during the first half of each period. Four output pairs are rotated copies of that wave. Each pair is shaped by two three-level select codes.

Pairs 0 and 1 move their phase in single ticks. Pairs 2 and 3 move it in double ticks. On pairs 2 and 3 the two extreme codes are replaced by divided or inverted clocks. Every select, including the test select, is captured only at a period boundary, so a change never cuts a pulse short. In test mode the generated wave is bypassed. Each pair then follows the reference input, applying its own invert or divide function to it.

Level codes on every select input are 2'b00 = LOW, 2'b01 = MID, 2'b10 = HIGH, and 2'b11 is read as MID. A pair's code index is 3*level(a) + level(b), running 0 (LL) to 8 (HH). Select a for pair p sits in `fsel_a[2p+1:2p]`, and select b sits in `fsel_b` at the same bits.

Top module: `psk_out_matrix`

## Requirements
- R1: The period length in ticks is 44 for range code 00, 26 for code 01 or 11, and 16 for code 10.
- R2: On pairs 0 and 1, code index i delays the nominal wave by (i-4) ticks. A negative value is an advance, taken modulo the period. Index 4 (MM) is zero skew: the output is high while counter value c < N/2.
- R3: On pairs 2 and 3, code indices 1 to 7 delay the nominal wave by 2*(i-4) ticks, modulo the period.
- R4: Index 0 (LL) on pairs 2 and 3 gives divide-by-2. The output is high for the whole first period after reset and flips at every period wrap.
- R5: Index 8 (HH) gives divide-by-4 on pair 2, high for two periods and then low for two, starting high after reset. On pair 3 it gives the zero-skew wave inverted.
- R6: Every skewed output is high for exactly N/2 ticks of each period.
- R7: The two outputs of a pair are always equal.
- R8: Changes to the range, function or test selects take effect only when the counter wraps from N-1 to 0.
- R9: With a nonzero test code, skew codes copy `ref_in` one tick later. Invert copies its complement. Divide-by-2 and divide-by-4 count rising edges of `ref_in`: they go high at the first rising edge after reset, and flip every one or every two rising edges.
- R10: Reset is synchronous and active high. It drives all outputs low while asserted. In the tick after the first non-reset edge, the outputs show counter value 0 of a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per time unit |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Level code choosing the period length |
| test_sel | input | 2 | Level code; nonzero selects reference bypass |
| ref_in | input | 1 | Reference waveform used in test mode |
| fsel_a | input | 8 | First level code of each pair, 2 bits per pair |
| fsel_b | input | 8 | Second level code of each pair, 2 bits per pair |
| q0 | output | 4 | First output of each pair |
| q1 | output | 4 | Second output of each pair |

## Verification
The hardest case to reach is a select change that arrives part way through a period. The outputs must keep the old shape until the wrap and switch cleanly on it. The same holds when the period length itself changes at that wrap. A directed sequence waits for a chosen counter value, changes one pair's code there, and checks points in the current period and in the next one where the old and new shapes differ. Seeded random segments then change every select at arbitrary ticks, mix the range codes and reset, and toggle the reference in test mode. A bench model tracks each wrap and divider phase and checks every output on every tick.

// File: rtl/psk_pkg.sv
package psk_pkg;

  typedef enum logic [1:0] {
    FN_SKEW = 2'd0,
    FN_DIV2 = 2'd1,
    FN_DIV4 = 2'd2,
    FN_INV  = 2'd3
  } pair_fn_e;

  // Rank of a level code: LOW=0, MID=1, HIGH=2; the unused code reads as MID.
  function automatic logic [1:0] lvl_rank(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b10:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/psk_period_ctr.sv
module psk_period_ctr #(
  parameter int unsigned N_LOW  = 44,
  parameter int unsigned N_MID  = 26,
  parameter int unsigned N_HIGH = 16,
  parameter int unsigned CW     = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    range_sel,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] n_q,
  output logic [CW-1:0] cnt_d,
  output logic [CW-1:0] n_d,
  output logic          load
);

  localparam logic [CW-1:0] NL = CW'(N_LOW);
  localparam logic [CW-1:0] NM = CW'(N_MID);
  localparam logic [CW-1:0] NH = CW'(N_HIGH);

  logic [CW-1:0] n_in;

  always_comb begin
    case (range_sel)
      2'b00:   n_in = NL;
      2'b10:   n_in = NH;
      default: n_in = NM;
    endcase
  end

  // A wrap (or reset) is the only point where new settings are captured.
  assign load  = rst | (cnt_q == n_q - 1'b1);
  assign n_d   = load ? n_in : n_q;
  assign cnt_d = rst ? (n_in - 1'b1) : (load ? '0 : cnt_q + 1'b1);

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
    n_q   <= n_d;
  end

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q < n_q);

  p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == n_q - 1'b1) |=> (cnt_q == '0));

  p_period_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != n_q - 1'b1) |=> $stable(n_q));

endmodule

// File: rtl/psk_div_ctr.sv
module psk_div_ctr #(
  parameter int unsigned DW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          ref_in,
  output logic [DW-1:0] dcnt_d,
  output logic [DW-1:0] rcnt_d
);

  logic [DW-1:0] dcnt_q;
  logic [DW-1:0] rcnt_q;
  logic          ref_q;
  logic          ref_rise;

  assign ref_rise = ref_in & ~ref_q;

  // Both counters start all-ones so that their first step lands on zero.
  assign dcnt_d = rst ? '1 : (load ? dcnt_q + 1'b1 : dcnt_q);
  assign rcnt_d = rst ? '1 : (ref_rise ? rcnt_q + 1'b1 : rcnt_q);

  always_ff @(posedge clk) begin
    dcnt_q <= dcnt_d;
    rcnt_q <= rcnt_d;
    ref_q  <= ref_in;
  end

  p_div_step_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (dcnt_q == DW'($past(dcnt_q) + 1'b1)));

  p_div_still_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dcnt_q));

endmodule

// File: rtl/psk_pair_out.sv
module psk_pair_out
  import psk_pkg::*;
#(
  parameter int unsigned CW     = 6,
  parameter bit          COARSE = 1'b0,
  parameter bit          HH_INV = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    sel_a,
  input  logic [1:0]    sel_b,
  input  logic          test_d,
  input  logic [CW-1:0] cnt_d,
  input  logic [CW-1:0] n_d,
  input  logic [1:0]    dcnt_d,
  input  logic [1:0]    rcnt_d,
  input  logic          ref_in,
  output logic          q
);

  logic [3:0]    cfg_q;
  logic [3:0]    cfg_d;
  logic [3:0]    idx;
  pair_fn_e      fn;
  logic          neg;
  logic [2:0]    mag;
  logic [CW-1:0] mag_w;
  logic [CW-1:0] delay;
  logic [CW-1:0] ph;
  logic [CW-1:0] half;
  logic          nom;
  logic          zero_nom;
  logic          q_d;

  assign cfg_d = load ? {sel_a, sel_b} : cfg_q;
  assign idx   = 4'(lvl_rank(cfg_d[3:2])) * 4'd3 + 4'(lvl_rank(cfg_d[1:0]));

  // Decode the code index into a function and a signed offset (neg, mag).
  generate
    if (COARSE) begin : g_coarse
      always_comb begin
        fn  = FN_SKEW;
        neg = 1'b0;
        mag = '0;
        if (idx == 4'd0) begin
          fn = FN_DIV2;
        end else if (idx == 4'd8) begin
          fn = HH_INV ? FN_INV : FN_DIV4;
        end else if (idx < 4'd4) begin
          neg = 1'b1;
          mag = 3'((4'd4 - idx) << 1);
        end else begin
          mag = 3'((idx - 4'd4) << 1);
        end
      end
    end else begin : g_fine
      always_comb begin
        fn  = FN_SKEW;
        neg = idx < 4'd4;
        mag = neg ? 3'(4'd4 - idx) : 3'(idx - 4'd4);
      end
    end
  endgenerate

  // Rotate the shared counter: a negative offset becomes a delay of N-k.
  assign mag_w    = {{(CW-3){1'b0}}, mag};
  assign delay    = neg ? (n_d - mag_w) : mag_w;
  assign ph       = (cnt_d >= delay) ? (cnt_d - delay) : (cnt_d + (n_d - delay));
  assign half     = n_d >> 1;
  assign nom      = ph < half;
  assign zero_nom = cnt_d < half;

  always_comb begin
    if (test_d) begin
      case (fn)
        FN_DIV2: q_d = ~rcnt_d[0];
        FN_DIV4: q_d = ~rcnt_d[1];
        FN_INV:  q_d = ~ref_in;
        default: q_d = ref_in;
      endcase
    end else begin
      case (fn)
        FN_DIV2: q_d = ~dcnt_d[0];
        FN_DIV4: q_d = ~dcnt_d[1];
        FN_INV:  q_d = ~zero_nom;
        default: q_d = nom;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
    q     <= rst ? 1'b0 : q_d;
  end

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_q));

  p_div2_flat_r4: assert property (@(posedge clk) disable iff (rst)
    (!test_d && fn == FN_DIV2 && !load) |=> $stable(q));

endmodule

// File: rtl/psk_out_matrix.sv
module psk_out_matrix #(
  parameter int unsigned NPAIR  = 4,
  parameter int unsigned N_FINE = 2,
  parameter int unsigned N_LOW  = 44,
  parameter int unsigned N_MID  = 26,
  parameter int unsigned N_HIGH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         range_sel,
  input  logic [1:0]         test_sel,
  input  logic               ref_in,
  input  logic [2*NPAIR-1:0] fsel_a,
  input  logic [2*NPAIR-1:0] fsel_b,
  output logic [NPAIR-1:0]   q0,
  output logic [NPAIR-1:0]   q1
);

  localparam int unsigned N_MAX = (N_LOW > N_MID)
                                  ? ((N_LOW > N_HIGH) ? N_LOW : N_HIGH)
                                  : ((N_MID > N_HIGH) ? N_MID : N_HIGH);
  localparam int unsigned CW    = $clog2(N_MAX + 1);

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    n_q;
  logic [CW-1:0]    cnt_d;
  logic [CW-1:0]    n_d;
  logic             load;
  logic [1:0]       dcnt_d;
  logic [1:0]       rcnt_d;
  logic             test_q;
  logic             test_d;
  logic [NPAIR-1:0] q_pair;

  psk_period_ctr #(
    .N_LOW (N_LOW),
    .N_MID (N_MID),
    .N_HIGH(N_HIGH),
    .CW    (CW)
  ) u_period (
    .clk      (clk),
    .rst      (rst),
    .range_sel(range_sel),
    .cnt_q    (cnt_q),
    .n_q      (n_q),
    .cnt_d    (cnt_d),
    .n_d      (n_d),
    .load     (load)
  );

  psk_div_ctr #(.DW(2)) u_div (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .ref_in(ref_in),
    .dcnt_d(dcnt_d),
    .rcnt_d(rcnt_d)
  );

  assign test_d = load ? (test_sel != 2'b00) : test_q;

  always_ff @(posedge clk) begin
    test_q <= test_d;
  end

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      psk_pair_out #(
        .CW    (CW),
        .COARSE(p >= N_FINE),
        .HH_INV(p == NPAIR - 1)
      ) u_pair (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .sel_a (fsel_a[2*p +: 2]),
        .sel_b (fsel_b[2*p +: 2]),
        .test_d(test_d),
        .cnt_d (cnt_d),
        .n_d   (n_d),
        .dcnt_d(dcnt_d),
        .rcnt_d(rcnt_d),
        .ref_in(ref_in),
        .q     (q_pair[p])
      );
    end
  endgenerate

  assign q0 = q_pair;
  assign q1 = q_pair;

  p_test_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(test_q));

  p_low_in_reset_r10: assert property (@(posedge clk)
    rst |=> (q0 == '0 && q1 == '0));

  p_first_wrap_r10: assert property (@(posedge clk)
    rst |=> load);

endmodule

// File: tb/psk_out_matrix_tb_top.sv
module psk_out_matrix_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    range_sel;
  logic [1:0]    test_sel;
  logic          ref_in;
  logic [7:0]    fsel_a;
  logic [7:0]    fsel_b;
  logic [NP-1:0] q0;
  logic [NP-1:0] q1;

  always #(CLK_PERIOD/2) clk = ~clk;

  psk_out_matrix dut_i (
    .clk(clk), .rst(rst), .range_sel(range_sel), .test_sel(test_sel),
    .ref_in(ref_in), .fsel_a(fsel_a), .fsel_b(fsel_b), .q0(q0), .q1(q1)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  // bench model state
  int m_cnt, m_n, m_d, m_r;
  bit m_refd, m_test, m_inrst;
  int m_a[NP];
  int m_b[NP];

  function automatic int range_n(int code);
    if (code == 0) return 44;
    if (code == 2) return 16;
    return 26;
  endfunction

  function automatic int lvl(int x);
    if (x == 0) return 0;
    if (x == 2) return 2;
    return 1;
  endfunction

  // kind: 0 skew, 1 div2, 2 div4, 3 invert
  function automatic int kind_of(int p, int a, int b);
    int i = 3 * lvl(a) + lvl(b);
    if (p < 2) return 0;
    if (i == 0) return 1;
    if (i == 8) return (p == 3) ? 3 : 2;
    return 0;
  endfunction

  function automatic int ofs_of(int p, int a, int b);
    int i = 3 * lvl(a) + lvl(b);
    return (p < 2) ? (i - 4) : 2 * (i - 4);
  endfunction

  function automatic bit exp_q(int p);
    int k = kind_of(p, m_a[p], m_b[p]);
    int ph;
    if (m_inrst) return 1'b0;
    if (m_test) begin
      if (k == 1) return (m_r % 2) == 0;
      if (k == 2) return ((m_r / 2) % 2) == 0;
      if (k == 3) return !ref_in;
      return ref_in;
    end
    if (k == 1) return (m_d % 2) == 0;
    if (k == 2) return ((m_d / 2) % 2) == 0;
    if (k == 3) return !(m_cnt < m_n / 2);
    ph = ((m_cnt - ofs_of(p, m_a[p], m_b[p])) % m_n + m_n) % m_n;
    return ph < m_n / 2;
  endfunction

  function automatic string tag_of(int p);
    int k = kind_of(p, m_a[p], m_b[p]);
    if (m_inrst) return "R10";
    if (m_test) return "R9";
    if (k == 1) return "R4";
    if (k >= 2) return "R5";
    return (p < 2) ? "R2" : "R3";
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, expv);
    end
  endtask

  task automatic load_cfg();
    for (int p = 0; p < NP; p++) begin
      m_a[p] = int'(fsel_a[2*p +: 2]);
      m_b[p] = int'(fsel_b[2*p +: 2]);
    end
    m_test = (test_sel != 2'b00);
  endtask

  task automatic model_edge();
    if (rst) begin
      m_n = range_n(int'(range_sel));
      m_cnt = m_n - 1;
      load_cfg();
      m_d = 3; m_r = 3; m_refd = ref_in; m_inrst = 1'b1;
    end else begin
      m_inrst = 1'b0;
      if (m_cnt == m_n - 1) begin
        m_n = range_n(int'(range_sel));
        m_cnt = 0;
        load_cfg();
        m_d = (m_d + 1) % 4;
      end else begin
        m_cnt++;
      end
      if (ref_in && !m_refd) m_r = (m_r + 1) % 4;
      m_refd = ref_in;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      bit e = exp_q(p);
      chk(q0[p] == e, tag_of(p), int'(q0[p]), int'(e));
      chk(q1[p] == q0[p], "R7", int'(q1[p]), int'(q0[p]));
    end
  endtask

  task automatic set_pair(int p, int a, int b);
    fsel_a[2*p +: 2] = 2'(a);
    fsel_b[2*p +: 2] = 2'(b);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int prev, rise1, rise2, hi, n, rises;
    void'($urandom(32'd20240611));
    rst = 1'b1; range_sel = 2'b00; test_sel = 2'b00; ref_in = 1'b0;
    fsel_a = 8'h55; fsel_b = 8'h55;
    repeat (3) step();
    chk(q0 == '0 && q1 == '0, "R10", int'({q1, q0}), 0);

    // R1 / R6: period and duty for every range code at zero skew
    for (int r = 0; r < 4; r++) begin
      rst = 1'b1; range_sel = 2'(r);
      repeat (2) step();
      rst = 1'b0;
      n = range_n(r);
      prev = 0; rise1 = -1; rise2 = -1; hi = 0;
      for (int k = 0; k < 2 * n; k++) begin
        step();
        if (k < n) hi += int'(q0[0]);
        if (prev == 0 && q0[0] == 1'b1) begin
          if (rise1 < 0) rise1 = k;
          else if (rise2 < 0) rise2 = k;
        end
        prev = int'(q0[0]);
      end
      chk(rise1 == 0, "R10", rise1, 0);
      chk(rise2 - rise1 == n, "R1", rise2 - rise1, n);
      chk(hi == n / 2, "R6", hi, n / 2);
    end

    // R8: code change in mid-period waits for the wrap (range MID, N=26)
    while (m_cnt != 5) step();
    set_pair(0, 0, 0);
    while (m_cnt != 11) step();
    chk(q0[0] == 1'b1, "R8", int'(q0[0]), 1);
    while (m_cnt != 0) step();
    while (m_cnt != 23) step();
    chk(q0[0] == 1'b1, "R8", int'(q0[0]), 1);

    // R9: reference bypass with divide and invert
    rst = 1'b1; test_sel = 2'b10; range_sel = 2'b10; ref_in = 1'b0;
    set_pair(0, 1, 1); set_pair(1, 2, 2); set_pair(2, 0, 0); set_pair(3, 2, 2);
    repeat (2) step();
    rst = 1'b0;
    step();
    rises = 0;
    for (int i = 0; i < 8; i++) begin
      ref_in = ~ref_in;
      if (ref_in) rises++;
      step();
      chk(q0[1] == ref_in, "R9", int'(q0[1]), int'(ref_in));
      chk(q0[3] == !ref_in, "R9", int'(q0[3]), int'(!ref_in));
      chk(q0[2] == (rises % 2 == 1), "R9", int'(q0[2]), int'(rises % 2 == 1));
    end

    // R4 / R5 directed: dividers on pairs 2 and 3 in normal mode
    rst = 1'b1; test_sel = 2'b00; range_sel = 2'b10;
    set_pair(2, 0, 0); set_pair(3, 2, 2);
    repeat (2) step();
    rst = 1'b0;
    for (int i = 0; i < 4 * 16; i++) step();
    set_pair(2, 2, 2);
    for (int i = 0; i < 5 * 16; i++) step();

    // constrained random segments
    for (int seg = 0; seg < 300; seg++) begin
      range_sel = 2'($urandom % 4);
      test_sel = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'b00;
      fsel_a = 8'($urandom);
      fsel_b = 8'($urandom);
      if ($urandom % 8 == 0) begin
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
      end
      for (int i = 0; i < 1 + int'($urandom % 90); i++) begin
        if ($urandom % 3 == 0) ref_in = ~ref_in;
        step();
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule